// File: doc/BRIEF.md
# TLB Replacement Victim Counter

This block supplies the entry number that a random-replacement TLB write uses. It keeps a 6-bit victim index that counts down by one each time an instruction retires. When the index has reached a software-programmed floor, the next retirement reloads it to the top value 31 instead of stepping down. The index therefore cycles through the entries from 31 down to the floor. Entries below the floor are never chosen, so software can pin them.

Software sees two registers through a register-number port. The victim register is read-only, and its upper 26 bits read as zero. The floor register is writable, but only its low 6 bits are kept. A write to the floor also sends the victim index back to 31 on the next cycle. The live index is also driven on a dedicated output, so the TLB write logic can use it without a register read.

Top module: `tlb_victim_ctr`

## Requirements
- R1: After reset the victim index is 31 and the floor is 0, so reads of register 1 return 31 and reads of register 6 return 0.
- R2: Reads of register 1 or register 6 return zero in bits 31 down to 6, and a read of any other register number returns zero.
- R3: A retire strobe while the index is above the floor, with no floor write in the same cycle, lowers the index by exactly one at the next clock edge.
- R4: A retire strobe while the index is less than or equal to the floor, with no floor write in the same cycle, loads 31 at the next clock edge.
- R5: While the floor holds a value of 31 or less, the index stays within floor to 31 inclusive.
- R6: A write to register 6 stores bits 5 to 0 of the write data as the floor, and reading register 6 returns that value zero-extended.
- R7: A write to register 6 sets the index to 31 at the next clock edge. This takes priority over a retire strobe in the same cycle.
- R8: A write to register 1, or to any register number other than 6, changes neither the index nor the floor. A cycle with no retire strobe and no floor write leaves both unchanged.
- R9: When the stored floor is above 31, the index stays at 31 across any number of retirements.
- R10: The victim index output always equals bits 5 to 0 of a register 1 read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| retireValid | input | 1 | One instruction retired this cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register number for the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 5 | Register number for the read |
| rdData | output | 32 | Read data, combinational |
| victimIdx | output | 6 | Current entry index for random replacement |

## Verification
The retire step and the floor write can land in the same cycle. Only the floor write may decide the next index, so the expected index is 31 and the new floor must still be stored. The vector table provokes this by raising the retire strobe and a register 6 write in one cycle while the index sits above the floor. The next index and both register reads are then compared with the values worked out from R7 and R6. The same table puts a write to register 1 beside an idle cycle, so it can show that the write leaves the index unchanged.

// File: rtl/victim_pkg.sv
package victim_pkg;

  // Strobes that the control half hands to the datapath half
  typedef struct packed {
    logic floorLoad;   // capture new floor from write data
    logic idxReload;   // load the top value into the index
    logic idxStep;     // lower the index by one
  } victimStrobe_t;

endpackage

// File: rtl/victim_ctrl.sv
module victim_ctrl
  import victim_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int ADDR_W     = 5,
  parameter int FLOOR_ADDR = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retireValid,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [IDX_W-1:0]  curIdx,
  input  logic [IDX_W-1:0]  curFloor,
  output victimStrobe_t     strobe
);

  localparam logic [IDX_W-1:0] TOP_VAL = IDX_W'((1 << (IDX_W - 1)) - 1);

  logic floorHit;
  logic atFloor;

  assign floorHit = wrEn && (wrAddr == ADDR_W'(FLOOR_ADDR));
  assign atFloor  = (curIdx <= curFloor);

  // A floor write outranks the retire step
  always_comb begin
    strobe           = '0;
    strobe.floorLoad = floorHit;
    if (floorHit) begin
      strobe.idxReload = 1'b1;
    end else if (retireValid) begin
      if (atFloor) strobe.idxReload = 1'b1;
      else         strobe.idxStep   = 1'b1;
    end
  end

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (retireValid && !floorHit && curIdx > curFloor) |=> curIdx == IDX_W'($past(curIdx) - 1'b1)); // R3

  AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (retireValid && !floorHit && curIdx <= curFloor) |=> curIdx == TOP_VAL); // R4

  AST_FLOOR_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    floorHit |=> curIdx == TOP_VAL); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!retireValid && !floorHit) |=> ($stable(curIdx) && $stable(curFloor))); // R8

endmodule

// File: rtl/victim_dp.sv
module victim_dp
  import victim_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int RAND_ADDR  = 1,
  parameter int FLOOR_ADDR = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  victimStrobe_t     strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [IDX_W-1:0]  idxQ,
  output logic [IDX_W-1:0]  floorQ
);

  localparam logic [IDX_W-1:0] TOP_VAL = IDX_W'((1 << (IDX_W - 1)) - 1);
  localparam int               PAD_W   = DATA_W - IDX_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= TOP_VAL;
    end else if (strobe.idxReload) begin
      idxQ <= TOP_VAL;
    end else if (strobe.idxStep) begin
      idxQ <= idxQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      floorQ <= '0;
    end else if (strobe.floorLoad) begin
      floorQ <= wrData[IDX_W-1:0];
    end
  end

  // Read port: both registers zero-extended, all other numbers read zero
  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(RAND_ADDR)) begin
      rdData = {{PAD_W{1'b0}}, idxQ};
    end else if (rdAddr == ADDR_W'(FLOOR_ADDR)) begin
      rdData = {{PAD_W{1'b0}}, floorQ};
    end
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:IDX_W] == '0); // R2

  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (floorQ <= TOP_VAL) |-> (idxQ >= floorQ && idxQ <= TOP_VAL)); // R5

  AST_HIGH_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (floorQ > TOP_VAL) |-> idxQ == TOP_VAL); // R9

  AST_FLOOR_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.floorLoad |=> floorQ == $past(wrData[IDX_W-1:0])); // R6

endmodule

// File: rtl/tlb_victim_ctr.sv
module tlb_victim_ctr
  import victim_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int RAND_ADDR  = 1,
  parameter int FLOOR_ADDR = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retireValid,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [IDX_W-1:0]  victimIdx
);

  victimStrobe_t    strobe;
  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] floorQ;

  victim_ctrl #(
    .IDX_W      (IDX_W),
    .ADDR_W     (ADDR_W),
    .FLOOR_ADDR (FLOOR_ADDR)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .retireValid (retireValid),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .curIdx      (idxQ),
    .curFloor    (floorQ),
    .strobe      (strobe)
  );

  victim_dp #(
    .IDX_W      (IDX_W),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .RAND_ADDR  (RAND_ADDR),
    .FLOOR_ADDR (FLOOR_ADDR)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .idxQ   (idxQ),
    .floorQ (floorQ)
  );

  assign victimIdx = idxQ;

  AST_PORT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_W'(RAND_ADDR)) |-> rdData[IDX_W-1:0] == victimIdx); // R10

endmodule

// File: tb/tlb_victim_ctr_bench.sv
`timescale 1ns/1ps
module tlb_victim_ctr_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        retireValid = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [4:0]  rdAddr = 5'd1;
  logic [31:0] rdData;
  logic [5:0]  victimIdx;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tlb_victim_ctr u_tlb_victim_ctr (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .victimIdx(victimIdx)
  );

  // {retire, wrEn, wrAddr[4:0], wrData[7:0], expIdx[5:0], expFloor[5:0]}
  localparam int NVEC = 18;
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 5'd6, 8'd29,  6'd31, 6'd29},  // R6 R7 floor write
    {1'b1, 1'b0, 5'd0, 8'd0,   6'd30, 6'd29},  // R3
    {1'b1, 1'b0, 5'd0, 8'd0,   6'd29, 6'd29},  // R3
    {1'b1, 1'b0, 5'd0, 8'd0,   6'd31, 6'd29},  // R4 at floor
    {1'b1, 1'b0, 5'd0, 8'd0,   6'd30, 6'd29},  // R3
    {1'b0, 1'b0, 5'd0, 8'd0,   6'd30, 6'd29},  // R8 idle
    {1'b0, 1'b1, 5'd1, 8'd5,   6'd30, 6'd29},  // R8 write to victim reg
    {1'b1, 1'b1, 5'd6, 8'd28,  6'd31, 6'd28},  // R7 retire plus floor write
    {1'b1, 1'b0, 5'd0, 8'd0,   6'd30, 6'd28},  // R3
    {1'b1, 1'b0, 5'd0, 8'd0,   6'd29, 6'd28},  // R3
    {1'b1, 1'b0, 5'd0, 8'd0,   6'd28, 6'd28},  // R3
    {1'b1, 1'b0, 5'd0, 8'd0,   6'd31, 6'd28},  // R4
    {1'b0, 1'b1, 5'd6, 8'hE5,  6'd31, 6'd37},  // R6 only low bits kept
    {1'b1, 1'b0, 5'd0, 8'd0,   6'd31, 6'd37},  // R9
    {1'b1, 1'b0, 5'd0, 8'd0,   6'd31, 6'd37},  // R9
    {1'b0, 1'b1, 5'd6, 8'd0,   6'd31, 6'd0},   // R6
    {1'b1, 1'b0, 5'd0, 8'd0,   6'd30, 6'd0},   // R3
    {1'b0, 1'b1, 5'd3, 8'd9,   6'd30, 6'd0}    // R8 other register
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Apply inputs at a falling edge; return at the next falling edge
  task automatic cycle(input logic r, input logic we, input logic [4:0] wa, input logic [31:0] wd);
    retireValid = r; wrEn = we; wrAddr = wa; wrData = wd;
    @(negedge clk);
    retireValid = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic readReg(input logic [4:0] a, output logic [31:0] v);
    rdAddr = a;
    #0.5;
    v = rdData;
  endtask

  task automatic resetDut();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [5:0]  model;
    resetDut();

    // R1 reset values
    readReg(5'd1, v); check("R1 victim after reset", v, 32'd31);
    readReg(5'd6, v); check("R1 floor after reset", v, 32'd0);
    check("R1 index port after reset", {26'd0, victimIdx}, 32'd31);

    // R2 unmapped register numbers read zero
    readReg(5'd0, v);  check("R2 unmapped reg 0", v, 32'd0);
    readReg(5'd31, v); check("R2 unmapped reg 31", v, 32'd0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [26:0] e;
      e = VEC[i];
      cycle(e[26], e[25], e[24:20], {24'd0, e[19:12]});
      readReg(5'd1, v);
      check($sformatf("R3/R4/R7/R8/R9 vector %0d index read", i), v, {26'd0, e[11:6]});
      check($sformatf("R10 vector %0d index port", i), {26'd0, victimIdx}, {26'd0, e[11:6]});
      readReg(5'd6, v);
      check($sformatf("R6/R2 vector %0d floor read", i), v, {26'd0, e[5:0]});
    end

    // R5 long run with floor 10, tracked by a model
    cycle(1'b0, 1'b1, 5'd6, 32'hFFFF_FF0A);
    model = 6'd31;
    for (int n = 0; n < 100; n++) begin
      cycle(1'b1, 1'b0, 5'd0, 32'd0);
      model = (model <= 6'd10) ? 6'd31 : model - 6'd1;
      readReg(5'd1, v);
      check("R5 index follows model", v, {26'd0, model});
      if (victimIdx < 6'd10 || victimIdx > 6'd31)
        check("R5 index inside range", {26'd0, victimIdx}, 32'd10);
    end

    // R8 writes of all-ones to the victim register are ignored
    readReg(5'd1, v);
    cycle(1'b0, 1'b1, 5'd1, 32'hFFFF_FFFF);
    check("R8 victim write ignored", {26'd0, victimIdx}, v);
    readReg(5'd6, v); check("R8 floor untouched", v, 32'd10);

    // R1 reset mid-run
    cycle(1'b1, 1'b0, 5'd0, 32'd0);
    resetDut();
    readReg(5'd1, v); check("R1 victim after second reset", v, 32'd31);
    readReg(5'd6, v); check("R1 floor after second reset", v, 32'd0);

    // R4 floor zero: counts 31 down to 0 then wraps
    for (int n = 0; n < 31; n++) cycle(1'b1, 1'b0, 5'd0, 32'd0);
    check("R3 reached zero", {26'd0, victimIdx}, 32'd0);
    cycle(1'b1, 1'b0, 5'd0, 32'd0);
    check("R4 wrap from zero", {26'd0, victimIdx}, 32'd31);

    summary();
  end

endmodule